// File: doc/BRIEF.md
# Periodic Down-Counter Compare Timer

This block is a 32-bit timer that counts down on a divided tick and raises a flag, and a level interrupt, when the count lands on a programmed compare value. Software reaches it through a small synchronous register port of word-addressed registers. Three tick-enable inputs from the clock tree are the possible count sources, and a control field picks one of them or none. A 12-bit divider then thins the chosen tick stream before it reaches the counter.

When the counter steps past zero it either reloads a programmed period or wraps to the all-ones value. Which of the two happens is set by a control bit. A start bit controls whether enabling the timer begins from a fresh value or carries on from the held count. A force bit makes a write to the period register take effect in the counter at once. A soft-reset bit returns the data registers to their reset values and keeps only the enable bits and the four halt-mode bits. The halt-mode bits are only stored and read back.

Top module: `dc_cmp_timer`

## Requirements
- R1: Word offsets 0 to 4 select, in order, control, status, period, compare and count. Offsets 5 to 7 read as zero and ignore writes. The count register is read-only. Read data is registered and shows the addressed register one clock after the address is presented. After reset, period is 0xFFFFFFFF and every other register is zero.
- R2: A control write stores bits 25:0 only. Bits 31:26 read back as zero, and the soft-reset bit (16) always reads as zero.
- R3: The source field, control bits 25:24, selects the count tick: 00 freezes the counter, 01 selects `tick_main`, 10 selects `tick_fast` and 11 selects `tick_slow`.
- R4: With divider field N (control bits 15:4), the counter steps once per N+1 selected ticks. The divider restarts when the run bit rises.
- R5: `irq` is high exactly one clock after the status flag, the match-interrupt-enable bit (control bit 2) and the run bit (control bit 0) are all set.
- R6: A status write with bit 0 set clears the flag. A write with bit 0 clear leaves it unchanged. If a match occurs in the same clock, setting the flag wins.
- R7: While the run bit is set, each divided tick lowers the count by one.
- R8: A tick taken at count zero loads the period value if the reload bit (control bit 3) is set, and 0xFFFFFFFF otherwise.
- R9: When a control write raises the run bit and the fresh-start bit (control bit 1) is set, the count becomes the period value if the written reload bit is set, and 0xFFFFFFFF otherwise. With fresh-start clear, the count keeps its held value.
- R10: When the force bit (control bit 17) is set, a period write also copies the written value into the count. This takes priority over a tick in the same clock.
- R11: When match-interrupt-enable is set and a tick moves the count onto the compare value, status bit 0 sets. It then stays set until it is cleared.
- R12: A control write with bit 16 set clears status, compare and count, and sets period to 0xFFFFFFFF. Control then keeps only bits 0, 1 and 18 to 21 of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| tick_main | input | 1 | Tick enable from the main clock source |
| tick_fast | input | 1 | Tick enable from the high-frequency source |
| tick_slow | input | 1 | Tick enable from the 32 kHz source |
| irq | output | 1 | Level interrupt on a compare match |

## Verification
The bench builds the block with its defaults, DATA_W of 32 and ADDR_W of 3. The 3-bit address reaches the three unmapped offsets 5 to 7, so R1 can be checked there. The full 32-bit width means the 0xFFFFFFFF wrap and fresh-start values are observed directly. The random phase keeps the divider field, period and compare values small, so reloads, divider roll-overs, compare matches and soft resets all occur many times within a few thousand clocks.

// File: rtl/dct_pkg.sv
package dct_pkg;
  // control register field positions
  localparam int CTRL_W      = 26;
  localparam int B_RUN       = 0;
  localparam int B_FRESH     = 1;
  localparam int B_MATCH_IE  = 2;
  localparam int B_RELOAD    = 3;
  localparam int B_DIV_LO    = 4;
  localparam int DIV_W       = 12;
  localparam int B_SOFTRST   = 16;
  localparam int B_LDFORCE   = 17;
  localparam int B_HALT_DBG  = 18;
  localparam int B_HALT_WAIT = 19;
  localparam int B_HALT_DOZE = 20;
  localparam int B_HALT_STOP = 21;
  localparam int B_SRC_LO    = 24;
  localparam int SRC_W       = 2;

  // word offsets
  localparam int OFF_CTRL = 0;
  localparam int OFF_STAT = 1;
  localparam int OFF_LOAD = 2;
  localparam int OFF_CMP  = 3;
  localparam int OFF_CNT  = 4;

  // control bits that survive a soft reset
  localparam logic [CTRL_W-1:0] KEEP_MASK =
    (CTRL_W'(1) << B_RUN) | (CTRL_W'(1) << B_FRESH) |
    (CTRL_W'(1) << B_HALT_DBG) | (CTRL_W'(1) << B_HALT_WAIT) |
    (CTRL_W'(1) << B_HALT_DOZE) | (CTRL_W'(1) << B_HALT_STOP);
  localparam logic [CTRL_W-1:0] SOFTRST_MASK = CTRL_W'(1) << B_SOFTRST;
endpackage

// File: rtl/dct_tick_gen.sv
module dct_tick_gen #(
  parameter int PRE_W = 12,
  parameter int NSRC  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_sel_i,
  input  logic [NSRC-1:0]  ticks_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  localparam int NSLOT = NSRC + 1;

  logic [NSLOT-1:0] slot_tick;
  logic             sel_tick;
  logic [PRE_W-1:0] pre_q;

  // slot 0 is the "no source" choice
  assign slot_tick[0] = 1'b0;
  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    assign slot_tick[g+1] = ticks_i[g];
  end
  assign sel_tick = slot_tick[src_sel_i];

  always_ff @(posedge clk) begin
    if (rst || !run_i || restart_i) begin
      pre_q <= '0;
    end else if (sel_tick) begin
      pre_q <= (pre_q == div_i) ? '0 : pre_q + PRE_W'(1);
    end
  end

  assign tick_o = run_i && !restart_i && sel_tick && (pre_q == div_i);

  a_r3_no_source_frozen: assert property (@(posedge clk) disable iff (rst)
    (src_sel_i == 2'b00) |-> !tick_o);

  a_r4_divided_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  input  logic         reload_sel_i,
  input  logic [W-1:0] load_val_i,
  input  logic         force_i,
  input  logic [W-1:0] force_val_i,
  input  logic [W-1:0] cmp_val_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] wrap_val;
  logic [W-1:0] step_val;

  assign wrap_val = reload_sel_i ? load_val_i : TOP;
  assign step_val = (cnt_q == '0) ? wrap_val : cnt_q - ONE;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (force_i) cnt_q <= force_val_i;
    else if (step_i)  cnt_q <= step_val;
  end

  assign cnt_o = cnt_q;
  assign hit_o = step_i && !force_i && (step_val == cmp_val_i);

  a_r7_step_down: assert property (@(posedge clk) disable iff (rst)
    (step_i && !force_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  a_r8_past_zero: assert property (@(posedge clk) disable iff (rst)
    (step_i && !force_i && cnt_q == '0) |=>
      (cnt_q == $past(reload_sel_i ? load_val_i : TOP)));
endmodule

// File: rtl/dct_flag.sv
module dct_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic wipe_i,
  input  logic gate_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst || wipe_i) flag_q <= 1'b0;
    else if (set_i)    flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag_q && gate_i;
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  a_r5_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (flag_q && gate_i) |=> irq_o);

  a_r5_irq_drop: assert property (@(posedge clk) disable iff (rst)
    !(flag_q && gate_i) |=> !irq_o);

  a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_q);

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i && !wipe_i) |=> flag_q);

  a_r11_set: assert property (@(posedge clk) disable iff (rst)
    (set_i && !wipe_i) |=> flag_q);
endmodule

// File: rtl/dc_cmp_timer.sv
module dc_cmp_timer
  import dct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_main,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] cmp_q;
  logic [DATA_W-1:0] cnt_w;
  logic [DATA_W-1:0] rdata_q;
  logic              flag_w;
  logic              step_w;
  logic              hit_w;

  logic wr_ctrl, wr_stat, wr_load, wr_cmp, wr_cnt;
  logic softrst_wr, run_rise;
  logic cnt_force;
  logic [DATA_W-1:0] cnt_force_val;

  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_stat = bus_we && (bus_addr == ADDR_W'(OFF_STAT));
  assign wr_load = bus_we && (bus_addr == ADDR_W'(OFF_LOAD));
  assign wr_cmp  = bus_we && (bus_addr == ADDR_W'(OFF_CMP));
  assign wr_cnt  = bus_we && (bus_addr == ADDR_W'(OFF_CNT));

  assign softrst_wr = wr_ctrl && bus_wdata[B_SOFTRST];
  assign run_rise   = wr_ctrl && !bus_wdata[B_SOFTRST] &&
                      bus_wdata[B_RUN] && !ctrl_q[B_RUN];

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      if (bus_wdata[B_SOFTRST]) ctrl_q <= bus_wdata[CTRL_W-1:0] & KEEP_MASK;
      else                      ctrl_q <= bus_wdata[CTRL_W-1:0] & ~SOFTRST_MASK;
    end
  end

  // period and compare registers
  always_ff @(posedge clk) begin
    if (rst || softrst_wr) begin
      load_q <= ALL_ONES;
      cmp_q  <= '0;
    end else begin
      if (wr_load) load_q <= bus_wdata;
      if (wr_cmp)  cmp_q  <= bus_wdata;
    end
  end

  // direct counter loads: soft reset, fresh start, forced period write
  always_comb begin
    cnt_force     = 1'b0;
    cnt_force_val = bus_wdata;
    if (softrst_wr) begin
      cnt_force     = 1'b1;
      cnt_force_val = '0;
    end else if (run_rise && bus_wdata[B_FRESH]) begin
      cnt_force     = 1'b1;
      cnt_force_val = bus_wdata[B_RELOAD] ? load_q : ALL_ONES;
    end else if (wr_load && ctrl_q[B_LDFORCE]) begin
      cnt_force     = 1'b1;
      cnt_force_val = bus_wdata;
    end
  end

  dct_tick_gen #(.PRE_W(DIV_W), .NSRC(3)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .src_sel_i (ctrl_q[B_SRC_LO +: SRC_W]),
    .ticks_i   ({tick_slow, tick_fast, tick_main}),
    .run_i     (ctrl_q[B_RUN]),
    .restart_i (softrst_wr || run_rise),
    .div_i     (ctrl_q[B_DIV_LO +: DIV_W]),
    .tick_o    (step_w)
  );

  dct_counter #(.W(DATA_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .step_i       (step_w),
    .reload_sel_i (ctrl_q[B_RELOAD]),
    .load_val_i   (load_q),
    .force_i      (cnt_force),
    .force_val_i  (cnt_force_val),
    .cmp_val_i    (cmp_q),
    .cnt_o        (cnt_w),
    .hit_o        (hit_w)
  );

  dct_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (hit_w && ctrl_q[B_MATCH_IE]),
    .clr_i  (wr_stat && bus_wdata[0]),
    .wipe_i (softrst_wr),
    .gate_i (ctrl_q[B_MATCH_IE] && ctrl_q[B_RUN]),
    .flag_o (flag_w),
    .irq_o  (irq)
  );

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      if (bus_addr == ADDR_W'(OFF_CTRL)) rdata_q <= DATA_W'(ctrl_q);
      if (bus_addr == ADDR_W'(OFF_STAT)) rdata_q <= DATA_W'(flag_w);
      if (bus_addr == ADDR_W'(OFF_LOAD)) rdata_q <= load_q;
      if (bus_addr == ADDR_W'(OFF_CMP))  rdata_q <= cmp_q;
      if (bus_addr == ADDR_W'(OFF_CNT))  rdata_q <= cnt_w;
    end
  end
  assign bus_rdata = rdata_q;

  a_r12_soft_reset: assert property (@(posedge clk) disable iff (rst)
    softrst_wr |=> (load_q == ALL_ONES && cmp_q == '0 && cnt_w == '0 && !flag_w));

  a_r1_count_read_only: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt && !step_w) |=> $stable(cnt_w));

  a_r9_fresh_full: assert property (@(posedge clk) disable iff (rst)
    (run_rise && bus_wdata[B_FRESH] && !bus_wdata[B_RELOAD]) |=> (cnt_w == ALL_ONES));

  a_r10_forced_load: assert property (@(posedge clk) disable iff (rst)
    (wr_load && ctrl_q[B_LDFORCE]) |=> (cnt_w == $past(bus_wdata)));
endmodule

// File: tb/dc_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module dc_cmp_timer_tb_top;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          tick_main = 1'b0, tick_fast = 1'b0, tick_slow = 1'b0;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [AW-1:0] last_addr = '0;

  always #4 clk = ~clk;

  dc_cmp_timer #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_main(tick_main), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .irq(irq)
  );

  // ---------------- reference model from the requirements ----------------
  logic [25:0] m_ctrl;
  logic        m_stat;
  logic [31:0] m_load, m_cmp, m_cnt, m_rdata;
  logic [11:0] m_pre;
  logic        m_irq;
  logic [25:0] n_ctrl;
  logic        n_stat;
  logic [31:0] n_load, n_cmp, n_cnt, nxt;
  logic [11:0] n_pre;
  logic        sel, pt;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = '0; m_stat = 0; m_load = '1; m_cmp = '0; m_cnt = '0;
      m_pre = '0; m_rdata = '0; m_irq = 0;
    end else begin
      case (bus_addr)
        3'd0: m_rdata = {6'b0, m_ctrl};
        3'd1: m_rdata = {31'b0, m_stat};
        3'd2: m_rdata = m_load;
        3'd3: m_rdata = m_cmp;
        3'd4: m_rdata = m_cnt;
        default: m_rdata = '0;
      endcase
      m_irq = m_stat && m_ctrl[2] && m_ctrl[0];
      case (m_ctrl[25:24])
        2'd1: sel = tick_main;
        2'd2: sel = tick_fast;
        2'd3: sel = tick_slow;
        default: sel = 1'b0;
      endcase
      pt = 0;
      n_pre = m_pre;
      if (!m_ctrl[0]) n_pre = '0;
      else if (sel) begin
        if (m_pre == m_ctrl[15:4]) begin pt = 1; n_pre = '0; end
        else n_pre = m_pre + 12'd1;
      end
      nxt = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
      n_cnt = pt ? nxt : m_cnt;
      n_stat = m_stat; n_ctrl = m_ctrl; n_load = m_load; n_cmp = m_cmp;
      if (bus_we && bus_addr == 3'd1 && bus_wdata[0]) n_stat = 0;
      if (pt && m_ctrl[2] && nxt == m_cmp && !(bus_we && bus_addr == 3'd2 && m_ctrl[17]))
        n_stat = 1;
      if (bus_we && bus_addr == 3'd0) begin
        if (bus_wdata[16]) begin
          n_ctrl = bus_wdata[25:0] & 26'h03C_0003;
          n_stat = 0; n_cmp = '0; n_load = '1; n_cnt = '0; n_pre = '0;
        end else begin
          n_ctrl = bus_wdata[25:0] & 26'h3FE_FFFF;
          if (bus_wdata[0] && !m_ctrl[0]) begin
            n_pre = '0;
            if (bus_wdata[1]) n_cnt = bus_wdata[3] ? m_load : 32'hFFFF_FFFF;
          end
        end
      end
      if (bus_we && bus_addr == 3'd2) begin
        n_load = bus_wdata;
        if (m_ctrl[17]) n_cnt = bus_wdata;
      end
      if (bus_we && bus_addr == 3'd3) n_cmp = bus_wdata;
      m_ctrl = n_ctrl; m_stat = n_stat; m_load = n_load; m_cmp = n_cmp;
      m_cnt = n_cnt; m_pre = n_pre;
    end
  end

  function automatic string tag_of(input logic [AW-1:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R11";
      3'd2: return "R10";
      3'd3: return "R12";
      3'd4: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus/tick cycle; compares the outputs of the previous edge first
  task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                     input logic [2:0] tk);
    @(negedge clk);
    chk(tag_of(last_addr), bus_rdata, m_rdata);
    chk("R5", {31'b0, irq}, {31'b0, m_irq});
    bus_we = we; bus_addr = a; bus_wdata = d;
    {tick_slow, tick_fast, tick_main} = tk;
    last_addr = a;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 3'b000);
  endtask

  task automatic rd_lit(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    cyc(1'b0, a, '0, 3'b000);
    cyc(1'b0, a, '0, 3'b000);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic ticks(input int n, input logic [2:0] tk);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd7, '0, tk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset values and unmapped offsets
    rd_lit(3'd0, 32'h0, "R1");
    rd_lit(3'd2, 32'hFFFF_FFFF, "R1");
    rd_lit(3'd4, 32'h0, "R1");
    wr(3'd6, 32'h0000_007B);
    rd_lit(3'd6, 32'h0, "R1");
    wr(3'd4, 32'h0000_004D);
    rd_lit(3'd4, 32'h0, "R1");

    // R2: upper bits dropped, soft-reset bit never stored
    wr(3'd0, 32'hFFFE_FFFE);
    rd_lit(3'd0, 32'h03FE_FFFE, "R2");
    wr(3'd0, 32'h0);

    // R9 fresh start from period, R3 source selection, R7 decrement, R8 reload
    wr(3'd2, 32'd5);
    wr(3'd0, 32'h0100_000B);
    rd_lit(3'd4, 32'd5, "R9");
    ticks(3, 3'b110);
    rd_lit(3'd4, 32'd5, "R3");
    ticks(3, 3'b001);
    rd_lit(3'd4, 32'd2, "R7");
    ticks(3, 3'b001);
    rd_lit(3'd4, 32'd5, "R8");

    // R11 match sets flag, R5 interrupt, R6 clear semantics
    wr(3'd3, 32'd4);
    wr(3'd0, 32'h0100_000F);
    ticks(1, 3'b001);
    rd_lit(3'd1, 32'd1, "R11");
    chk("R5", {31'b0, irq}, 32'd1);
    wr(3'd1, 32'h0000_0002);
    rd_lit(3'd1, 32'd1, "R6");
    wr(3'd1, 32'h0000_0001);
    rd_lit(3'd1, 32'd0, "R6");
    ticks(2, 3'b000);
    chk("R5", {31'b0, irq}, 32'd0);

    // R4: divide by three
    wr(3'd0, 32'h0100_002F);
    ticks(5, 3'b001);
    rd_lit(3'd4, 32'd3, "R4");

    // R10: forced period write
    wr(3'd0, 32'h0102_002F);
    wr(3'd2, 32'd9);
    rd_lit(3'd4, 32'd9, "R10");

    // R12: soft reset
    wr(3'd0, 32'h0109_0001);
    rd_lit(3'd0, 32'h0008_0001, "R12");
    rd_lit(3'd2, 32'hFFFF_FFFF, "R12");
    rd_lit(3'd3, 32'h0, "R12");
    rd_lit(3'd4, 32'h0, "R12");
    rd_lit(3'd1, 32'h0, "R12");

    // R9: resume without fresh start, then fresh start without reload
    wr(3'd0, 32'h0002_0000);
    wr(3'd2, 32'd7);
    wr(3'd0, 32'h0100_0001);
    rd_lit(3'd4, 32'd7, "R9");
    ticks(2, 3'b001);
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h0100_0003);
    rd_lit(3'd4, 32'hFFFF_FFFF, "R9");

    // constrained random phase, checked against the model every clock
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      logic [AW-1:0] a;
      logic we;
      we = ($urandom_range(0, 9) < 4);
      a  = AW'($urandom_range(0, 7));
      d  = $urandom;
      if (we && a == 3'd0) begin
        d[15:4] = 12'($urandom_range(0, 3));
        d[16]   = ($urandom_range(0, 15) == 0);
      end else if (we && (a == 3'd2 || a == 3'd3)) begin
        if ($urandom_range(0, 7) != 0) d = $urandom_range(0, 20);
      end else if (we && a == 3'd1) begin
        d[0] = ($urandom_range(0, 3) == 0);
      end
      cyc(we, a, d, 3'($urandom));
    end
    cyc(1'b0, 3'd7, '0, 3'b000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule